// File: doc/BRIEF.md
# Indexed Chipset Configuration Register File

This block keeps a bank of sixteen byte-wide chipset configuration registers behind a pair of I/O ports. Software first writes a register number to the index port (0x22) and then reads or writes the chosen register through the data port (0x23). The register numbers that exist are 0x60 to 0x6F; the register at offset k sits at index 0x60 + k.

Every register has its own write mask: only the writable bits of the incoming byte are taken, and the other bits keep what they held. Reset puts every register to its start-up value, passed through that same mask. The miscellaneous register at 0x6F also drives the A20 gate, which leaves the block as a live signal. When 0x6F is read, bit 1 shows that live gate. Each accepted data write raises a one-cycle change strobe carrying the register index, so that the logic depending on a register can recompute. What each register controls is outside this block.

Top module: `cfgreg_file`

## Requirements
- R1: A write to I/O address 0x22 latches the full 8-bit data byte as the current index. A read of 0x22 returns that index. Reset clears the index to 0x00.
- R2: Reset loads register offset k (index 0x60+k) with default[k] AND mask[k]. The defaults for offsets 0..15 are 00,00,00,00,00,7F,00,00,00,00,A0,63,10,00,00,12. Register 0x6F therefore reads 0x02 after reset.
- R3: A data write to 0x6F takes only the bits set in mask 0xE6 (bits 7,6,5,2,1). Bits 0, 3 and 4 keep their value, which is zero from reset, so writing 0xFF reads back 0xE6.
- R4: The output a20_gate is 1 after reset. It takes the value of data bit 1 on the clock edge of each write to 0x6F, and it changes at no other time.
- R5: One cycle after each data write whose index lies in 0x60..0x6F, chg_stb is high for exactly one cycle and chg_idx holds that index. No other access raises chg_stb.
- R6: A read of the data port with index 0x6F returns the stored byte with bit 1 replaced by the live a20_gate.
- R7: With an index outside 0x60..0x6F, a data-port read returns 0xFF, and a data-port write changes no register and raises no strobe.
- R8: A read of any I/O address other than 0x22 and 0x23 returns 0xFF.
- R9: Registers 0x60 to 0x6E are fully writable, and a data-port read returns the byte last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, sampled on the rising edge |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for io_addr (combinational) |
| a20_gate | output | 1 | Live A20 gate state |
| chg_stb | output | 1 | One-cycle pulse after an accepted data write |
| chg_idx | output | 8 | Index of the register written, valid with chg_stb |

## Verification
A wrong latched index shows up on the very next data-port read: either the wrong register's byte or 0xFF comes back. A register bank that drops a mask bit, or a bad reset default, shows up in the first readback after the write or after reset. A wrong A20 state shows up at once on a20_gate, one edge after the write to 0x6F, and in bit 1 of a 0x6F readback in the same cycle. A wrong strobe is seen exactly one cycle after the write, both as a pulse that is missing or extra and as a wrong chg_idx.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        PORT_NONE  = 2'd0,
        PORT_INDEX = 2'd1,
        PORT_DATA  = 2'd2
    } port_sel_e;

    // Bit of the miscellaneous register that mirrors the A20 gate.
    localparam int unsigned A20_BIT = 1;

    // Writable bits of the miscellaneous register.
    localparam byte_t MISC_MASK = 8'hE6;

    // Start-up value per register offset.
    function automatic byte_t reset_value(int unsigned off);
        byte_t v;
        case (off)
            5:       v = 8'h7F;
            10:      v = 8'hA0;
            11:      v = 8'h63;
            12:      v = 8'h10;
            15:      v = 8'h12;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    // Writable-bit mask per register offset.
    function automatic byte_t write_mask(int unsigned off, int unsigned misc_off);
        return (off == misc_off) ? MISC_MASK : 8'hFF;
    endfunction

endpackage

// File: rtl/cfgreg_decode.sv
module cfgreg_decode
    import cfgreg_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned IDX_PORT  = 16'h0022,
    parameter int unsigned DATA_PORT = 16'h0023,
    parameter int unsigned IDX_BASE  = 8'h60,
    parameter int unsigned NUM_REGS  = 16,
    localparam int unsigned OFF_W    = $clog2(NUM_REGS)
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  byte_t             idx_q,
    output port_sel_e         sel,
    output logic              idx_wr,
    output logic              data_wr,
    output logic              idx_valid,
    output logic [OFF_W-1:0]  offset
);
    localparam logic [8:0] LO = 9'(IDX_BASE);
    localparam logic [8:0] HI = 9'(IDX_BASE + NUM_REGS);

    logic [8:0] idx_ext;
    byte_t      diff;

    always_comb begin
        if (io_addr == ADDR_W'(IDX_PORT))       sel = PORT_INDEX;
        else if (io_addr == ADDR_W'(DATA_PORT)) sel = PORT_DATA;
        else                                    sel = PORT_NONE;
    end

    assign idx_ext   = {1'b0, idx_q};
    assign idx_valid = (idx_ext >= LO) && (idx_ext < HI);
    assign diff      = idx_q - 8'(IDX_BASE);
    assign offset    = diff[OFF_W-1:0];
    assign idx_wr    = io_wr && (sel == PORT_INDEX);
    assign data_wr   = io_wr && (sel == PORT_DATA);
endmodule

// File: rtl/cfgreg_bank.sv
module cfgreg_bank
    import cfgreg_pkg::*;
#(
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned MISC_OFF = 15,
    localparam int unsigned OFF_W   = $clog2(NUM_REGS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         data_wr,
    input  logic                         idx_valid,
    input  logic [OFF_W-1:0]             offset,
    input  byte_t                        wdata,
    output logic [NUM_REGS-1:0][7:0]     regs_q,
    output logic                         a20_q
);
    localparam byte_t MISC_RST = reset_value(MISC_OFF) & write_mask(MISC_OFF, MISC_OFF);

    logic wr_ok;
    assign wr_ok = data_wr && idx_valid;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam byte_t MASK = write_mask(g, MISC_OFF);
        localparam byte_t RST  = reset_value(g) & MASK;
        byte_t q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= RST;
            end else if (wr_ok && (offset == OFF_W'(g))) begin
                q <= (q & ~MASK) | (wdata & MASK);
            end
        end
        assign regs_q[g] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a20_q <= MISC_RST[A20_BIT];
        end else if (wr_ok && (offset == OFF_W'(MISC_OFF))) begin
            a20_q <= wdata[A20_BIT];
        end
    end
endmodule

// File: rtl/cfgreg_rdmux.sv
module cfgreg_rdmux
    import cfgreg_pkg::*;
#(
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned MISC_OFF = 15,
    localparam int unsigned OFF_W   = $clog2(NUM_REGS)
) (
    input  port_sel_e                sel,
    input  logic                     idx_valid,
    input  logic [OFF_W-1:0]         offset,
    input  byte_t                    idx_q,
    input  logic [NUM_REGS-1:0][7:0] regs_q,
    input  logic                     a20_q,
    output byte_t                    rdata
);
    always_comb begin
        rdata = 8'hFF;
        case (sel)
            PORT_INDEX: rdata = idx_q;
            PORT_DATA: begin
                if (idx_valid) begin
                    rdata = regs_q[offset];
                    if (offset == OFF_W'(MISC_OFF)) begin
                        rdata[A20_BIT] = a20_q;
                    end
                end
            end
            default: rdata = 8'hFF;
        endcase
    end
endmodule

// File: rtl/cfgreg_file.sv
module cfgreg_file
    import cfgreg_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned IDX_PORT  = 16'h0022,
    parameter int unsigned DATA_PORT = 16'h0023,
    parameter int unsigned IDX_BASE  = 8'h60,
    parameter int unsigned NUM_REGS  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              a20_gate,
    output logic              chg_stb,
    output logic [7:0]        chg_idx
);
    localparam int unsigned OFF_W    = $clog2(NUM_REGS);
    localparam int unsigned MISC_OFF = NUM_REGS - 1;

    byte_t                    idx_q;
    port_sel_e                sel;
    logic                     idx_wr;
    logic                     data_wr;
    logic                     idx_valid;
    logic [OFF_W-1:0]         offset;
    logic [NUM_REGS-1:0][7:0] regs_q;
    logic                     a20_q;
    logic                     stb_q;
    byte_t                    stb_idx_q;

    cfgreg_decode #(
        .ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT),
        .IDX_BASE(IDX_BASE), .NUM_REGS(NUM_REGS)
    ) u_decode (
        .io_addr(io_addr), .io_wr(io_wr), .idx_q(idx_q),
        .sel(sel), .idx_wr(idx_wr), .data_wr(data_wr),
        .idx_valid(idx_valid), .offset(offset)
    );

    cfgreg_bank #(.NUM_REGS(NUM_REGS), .MISC_OFF(MISC_OFF)) u_bank (
        .clk(clk), .rst(rst), .data_wr(data_wr), .idx_valid(idx_valid),
        .offset(offset), .wdata(io_wdata), .regs_q(regs_q), .a20_q(a20_q)
    );

    cfgreg_rdmux #(.NUM_REGS(NUM_REGS), .MISC_OFF(MISC_OFF)) u_rdmux (
        .sel(sel), .idx_valid(idx_valid), .offset(offset), .idx_q(idx_q),
        .regs_q(regs_q), .a20_q(a20_q), .rdata(io_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q     <= 8'h00;
            stb_q     <= 1'b0;
            stb_idx_q <= 8'h00;
        end else begin
            if (idx_wr) idx_q <= io_wdata;
            stb_q <= data_wr && idx_valid;
            if (data_wr && idx_valid) stb_idx_q <= idx_q;
        end
    end

    assign a20_gate = a20_q;
    assign chg_stb  = stb_q;
    assign chg_idx  = stb_idx_q;
endmodule

// File: rtl/cfgreg_file_chk.sv
module cfgreg_file_chk #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_PORT = 16'h0023,
    parameter int unsigned IDX_BASE  = 8'h60,
    parameter int unsigned NUM_REGS  = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic [ADDR_W-1:0]        io_addr,
    input logic                     io_wr,
    input logic [7:0]               io_wdata,
    input logic [7:0]               io_rdata,
    input logic                     a20_gate,
    input logic                     chg_stb,
    input logic [7:0]               chg_idx,
    input logic [7:0]               idx_q,
    input logic [NUM_REGS-1:0][7:0] regs_q
);
    localparam int unsigned MISC_OFF = NUM_REGS - 1;
    localparam logic [7:0]  MISC_IDX = 8'(IDX_BASE + MISC_OFF);
    localparam logic [7:0]  KEEP     = 8'h19;

    logic on_data, in_rng, acc_wr, misc_wr;
    assign on_data = (io_addr == ADDR_W'(DATA_PORT));
    assign in_rng  = ({1'b0, idx_q} >= 9'(IDX_BASE)) && ({1'b0, idx_q} < 9'(IDX_BASE + NUM_REGS));
    assign acc_wr  = io_wr && on_data && in_rng;
    assign misc_wr = io_wr && on_data && (idx_q == MISC_IDX);

    // R3: bits outside the mask of the miscellaneous register never change
    a_r3_reserved_kept: assert property (@(posedge clk) disable iff (rst)
        misc_wr |=> ((regs_q[MISC_OFF] & KEEP) == ($past(regs_q[MISC_OFF]) & KEEP)));

    // R4: gate follows bit 1 of a write to the miscellaneous register
    a_r4_a20_follows: assert property (@(posedge clk) disable iff (rst)
        misc_wr |=> (a20_gate == $past(io_wdata[1])));

    // R4: gate holds otherwise
    a_r4_a20_holds: assert property (@(posedge clk) disable iff (rst)
        !misc_wr |=> $stable(a20_gate));

    // R5: strobe and index after an accepted write
    a_r5_strobe_on_write: assert property (@(posedge clk) disable iff (rst)
        acc_wr |=> (chg_stb && (chg_idx == $past(idx_q))));

    // R5: no strobe without an accepted write
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !acc_wr |=> !chg_stb);

    // R6: readback of the miscellaneous register shows the live gate
    a_r6_live_gate: assert property (@(posedge clk) disable iff (rst)
        (on_data && (idx_q == MISC_IDX)) |-> (io_rdata[1] == a20_gate));

    // R7: out-of-range index reads as all ones
    a_r7_unmapped_ff: assert property (@(posedge clk) disable iff (rst)
        (on_data && !in_rng) |-> (io_rdata == 8'hFF));
endmodule

bind cfgreg_file cfgreg_file_chk #(
    .ADDR_W(ADDR_W), .DATA_PORT(DATA_PORT), .IDX_BASE(IDX_BASE), .NUM_REGS(NUM_REGS)
) u_chk (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .a20_gate(a20_gate), .chg_stb(chg_stb), .chg_idx(chg_idx),
    .idx_q(idx_q), .regs_q(regs_q)
);

// File: tb/cfgreg_file_bench.sv
module cfgreg_file_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = 16'h0000;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic        a20_gate;
    logic        chg_stb;
    logic [7:0]  chg_idx;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    cfgreg_file u_cfgreg_file (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .a20_gate(a20_gate), .chg_stb(chg_stb), .chg_idx(chg_idx)
    );

    // Expected reset contents (default AND mask), offsets 0..15.
    localparam logic [7:0] EXP_RST [16] = '{
        8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h7F, 8'h00, 8'h00,
        8'h00, 8'h00, 8'hA0, 8'h63, 8'h10, 8'h00, 8'h00, 8'h02};

    // {req[3:0], write, addr[15:0], data_or_expected[7:0]}
    localparam int NV = 30;
    localparam logic [28:0] VEC [NV] = '{
        {4'd2, 1'b1, 16'h0022, 8'h60}, {4'd2, 1'b0, 16'h0023, 8'h00}, // R2
        {4'd2, 1'b1, 16'h0022, 8'h65}, {4'd2, 1'b0, 16'h0023, 8'h7F},
        {4'd2, 1'b1, 16'h0022, 8'h6A}, {4'd2, 1'b0, 16'h0023, 8'hA0},
        {4'd2, 1'b1, 16'h0022, 8'h6B}, {4'd2, 1'b0, 16'h0023, 8'h63},
        {4'd2, 1'b1, 16'h0022, 8'h6C}, {4'd2, 1'b0, 16'h0023, 8'h10},
        {4'd2, 1'b1, 16'h0022, 8'h6F}, {4'd2, 1'b0, 16'h0023, 8'h02},
        {4'd3, 1'b1, 16'h0023, 8'hFF}, {4'd3, 1'b0, 16'h0023, 8'hE6}, // R3
        {4'd3, 1'b1, 16'h0023, 8'h19}, {4'd3, 1'b0, 16'h0023, 8'h00},
        {4'd3, 1'b1, 16'h0023, 8'h22}, {4'd3, 1'b0, 16'h0023, 8'h22},
        {4'd9, 1'b1, 16'h0022, 8'h61}, {4'd9, 1'b1, 16'h0023, 8'h5A}, // R9
        {4'd9, 1'b0, 16'h0023, 8'h5A},
        {4'd9, 1'b1, 16'h0022, 8'h6E}, {4'd9, 1'b1, 16'h0023, 8'hC3},
        {4'd9, 1'b0, 16'h0023, 8'hC3},
        {4'd7, 1'b1, 16'h0022, 8'h70}, {4'd7, 1'b0, 16'h0023, 8'hFF}, // R7
        {4'd7, 1'b1, 16'h0022, 8'h5F}, {4'd7, 1'b0, 16'h0023, 8'hFF},
        {4'd1, 1'b0, 16'h0022, 8'h5F},                                 // R1
        {4'd8, 1'b0, 16'h0040, 8'hFF}};                                // R8

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr  = a;
        io_wdata = d;
        io_wr    = 1'b1;
        @(negedge clk);
        io_wr    = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a;
        #1;
        d = io_rdata;
    endtask

    task automatic check_reset_state();
        logic [7:0] r;
        check("R4 a20 after reset", {7'd0, a20_gate}, 8'h01);
        check("R5 no strobe after reset", {7'd0, chg_stb}, 8'h00);
        io_read(16'h0022, r);
        check("R1 index after reset", r, 8'h00);
        io_read(16'h0023, r);
        check("R7 data read at index 00", r, 8'hFF);
        for (int k = 0; k < 16; k++) begin
            io_write(16'h0022, 8'(8'h60 + k));
            io_read(16'h0023, r);
            check("R2 reset default", r, EXP_RST[k]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_reset_state();

        // Vector walk
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][24]) begin
                io_write(VEC[v][23:8], VEC[v][7:0]);
            end else begin
                io_read(VEC[v][23:8], r);
                check($sformatf("R%0d vector %0d", VEC[v][28:25], v), r, VEC[v][7:0]);
            end
        end

        // R4 / R6: gate tracking and readback
        io_write(16'h0022, 8'h6F);
        io_write(16'h0023, 8'h00);
        check("R4 a20 cleared", {7'd0, a20_gate}, 8'h00);
        io_read(16'h0023, r);
        check("R6 readback gate low", r, 8'h00);
        io_write(16'h0023, 8'hE2);
        check("R4 a20 set", {7'd0, a20_gate}, 8'h01);
        io_read(16'h0023, r);
        check("R6 readback gate high", r, 8'hE2);
        io_write(16'h0022, 8'h60);
        io_write(16'h0023, 8'hFD);
        check("R4 a20 unchanged by other reg", {7'd0, a20_gate}, 8'h01);

        // R5: strobe timing and index
        io_write(16'h0022, 8'h63);
        check("R5 no strobe on index write", {7'd0, chg_stb}, 8'h00);
        io_write(16'h0023, 8'h44);
        check("R5 strobe after data write", {7'd0, chg_stb}, 8'h01);
        check("R5 strobe index", chg_idx, 8'h63);
        @(negedge clk);
        check("R5 strobe one cycle", {7'd0, chg_stb}, 8'h00);

        // R7: out-of-range write ignored
        io_write(16'h0022, 8'h70);
        io_write(16'h0023, 8'h33);
        check("R7 no strobe out of range", {7'd0, chg_stb}, 8'h00);
        io_write(16'h0022, 8'h63);
        io_read(16'h0023, r);
        check("R7 reg 63 untouched", r, 8'h44);
        io_write(16'h0022, 8'h60);
        io_read(16'h0023, r);
        check("R7 reg 60 untouched", r, 8'hFD);

        // R8: write to another address has no effect on the index
        io_write(16'h0024, 8'h6B);
        io_read(16'h0022, r);
        check("R8 foreign write leaves index", r, 8'h60);

        // Mid-run reset
        io_write(16'h0022, 8'h6F);
        io_write(16'h0023, 8'h00);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check_reset_state();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule